// File: doc/BRIEF.md
# Reversible-Gate Ripple Arithmetic Unit

This block is a combinational W-bit arithmetic unit whose datapath is composed entirely of reversible logic primitives. Two operands, a two-bit mode and a carry input produce a W-bit result and a carry output. The four modes select which value the ripple adder adds to `op_a`: zero, `op_b`, the bitwise inverse of `op_b`, or all ones. The carry input then gives increment, add, add-plus-one, subtract, decrement and pass-through behaviour from one adder.

Every bit is a slice of two parts. The first is an operand selector made of controlled-swap gates, one controlled-NOT and one inverter. The second is a full adder with a single constant-zero line. The adder is either a cascade of two three-line Peres-style gates or one four-line gate, and a parameter picks between them. The lines that the gates leave unused (garbage) are kept inside each slice and gathered at the top for the bound checker. The unit has no clock and no state. The slice carries ripple upward from bit 0.

Top module: `rev_arith_unit`

## Requirements
- R1: With `mode` = 2'b00 the added operand is zero, so {`carry_out`,`result`} = `op_a` + `carry_in` (transfer when `carry_in`=0, increment when 1).
- R2: With `mode` = 2'b01 the added operand is `op_b`, so {`carry_out`,`result`} = `op_a` + `op_b` + `carry_in`.
- R3: With `mode` = 2'b10 the added operand is ~`op_b`. With `carry_in`=1 `result` is `op_a` − `op_b` modulo 2^W, and `carry_out` is 1 exactly when `op_a` ≥ `op_b`.
- R4: With `mode` = 2'b11 the added operand is all ones. With `carry_in`=0 `result` = `op_a` − 1 and `carry_out` is 0 only for `op_a`=0. With `carry_in`=1 `result` = `op_a` and `carry_out` = 1.
- R5: Carries ripple from bit 0 to bit W−1. `carry_in` enters bit 0 and the carry out of bit W−1 is `carry_out`, so all-ones plus one in `mode` 2'b00 gives `result`=0 with `carry_out`=1.
- R6: The unit is purely combinational: `result` and `carry_out` follow an input change without any clock edge.
- R7: Both adder variants, selected by the `ADDER` parameter (two Peres-style gates, or one four-line gate), give identical `result` and `carry_out` for every input. Each variant uses one constant-zero line per slice, and its garbage lines carry `op_a` and `op_a` XOR the selected operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First addend, always taken unmodified |
| op_b | input | W | Source of the second addend, shaped by `mode` |
| mode | input | 2 | Operand choice: 00 zero, 01 `op_b`, 10 ~`op_b`, 11 all ones |
| carry_in | input | 1 | Carry into bit 0 |
| result | output | W | Sum bits |
| carry_out | output | 1 | Carry out of bit W−1 |

## Verification
All eight combinations of mode and carry input are applied with operand pairs of all zeros, all ones, single low bit against all ones, and the sign-boundary pair 0x80/0x7F. Each pattern is then followed by random operands. The all-ones and all-zeros pairs separate a correct full-length ripple from a chain that drops the carry at one slice. The 0x80/0x7F pair separates subtraction borrow from a plain add, and the decrement-of-zero case catches an operand selector that outputs zero instead of all ones. Two instances with different adder variants are compared against one behavioural sum, and one pattern is re-checked a fraction of a cycle after an input change to show that no clock is involved.

// File: rtl/rev_arith_pkg.sv
// Package: shared types for the reversible arithmetic unit.
// Assumes: nothing; holds only type definitions.
package rev_arith_pkg;

    // Operand choice driven by the two mode bits.
    typedef enum logic [1:0] {
        MODE_ZERO   = 2'b00,
        MODE_B      = 2'b01,
        MODE_NOT_B  = 2'b10,
        MODE_ONES   = 2'b11
    } mode_e;

    // Which reversible full-adder structure each slice builds.
    typedef enum logic {
        ADDER_PERES_PAIR = 1'b0,
        ADDER_QUAD_GATE  = 1'b1
    } adder_kind_e;

    // Lines left over by the gates of one slice (garbage outputs).
    typedef struct packed {
        logic sel_parity;   // copy of mode[0]^mode[1] after the last swap
        logic sel_g0;       // unselected line of the first swap
        logic sel_g1;       // unselected line of the second swap
        logic add_g0;       // copy of the first addend bit
        logic add_g1;       // first addend XOR selected operand
    } slice_garbage_t;

endpackage

// File: rtl/rev_gates.sv
// Module: rev_not_gate - 1x1 reversible inverter.
// Assumes: single-bit input, no state.
module rev_not_gate (
    input  logic a,
    output logic p
);
    // Invert the only line.
    always_comb p = ~a;
endmodule

// Module: rev_cnot_gate - 2x2 controlled-NOT; control passes, target XORed.
// Assumes: single-bit lines, no state.
module rev_cnot_gate (
    input  logic ctl,
    input  logic tgt,
    output logic ctl_o,
    output logic tgt_o
);
    // Pass the control and flip the target when the control is high.
    always_comb begin
        ctl_o = ctl;
        tgt_o = ctl ^ tgt;
    end
endmodule

// Module: rev_swap_gate - 3x3 controlled swap; the two data lines trade
// places when the control is 1.
// Assumes: single-bit lines, no state.
module rev_swap_gate (
    input  logic ctl,
    input  logic x,
    input  logic y,
    output logic ctl_o,
    output logic q,
    output logic r
);
    // Sum-of-products form of the conditional exchange.
    always_comb begin
        ctl_o = ctl;
        q     = (~ctl & x) | (ctl & y);
        r     = (ctl & x) | (~ctl & y);
    end
endmodule

// Module: rev_peres_gate - 3x3 gate: p=a, q=a^b, r=(a&b)^c.
// Assumes: single-bit lines, no state.
module rev_peres_gate (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    // Produce the copy, the parity and the AND-accumulated line.
    always_comb begin
        p = a;
        q = a ^ b;
        r = (a & b) ^ c;
    end
endmodule

// Module: rev_quad_gate - 4x4 gate: p=a, q=a^b, r=a^b^c,
// s=((a^b)&c)^(a&b)^d. With d=0, r is the sum and s the carry.
// Assumes: single-bit lines, no state.
module rev_quad_gate (
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    output logic p,
    output logic q,
    output logic r,
    output logic s
);
    logic ab_x;

    // Shared parity of a and b feeds three outputs.
    always_comb ab_x = a ^ b;

    // Map the four inputs onto the four outputs.
    always_comb begin
        p = a;
        q = ab_x;
        r = ab_x ^ c;
        s = (ab_x & c) ^ (a & b) ^ d;
    end
endmodule

// File: rtl/rev_operand_sel.sv
// Module: rev_operand_sel - picks the adder's second operand bit from b and
// the two mode bits using only reversible gates:
//   00 -> 0, 01 -> b, 10 -> ~b, 11 -> 1.
// A first swap controlled by mode[1] picks b or ~b. A CNOT forms the mode
// parity. A second swap controlled by that parity keeps the picked value
// (modes 01/10) or routes mode[0] as the constant (modes 00/11).
// Assumes: single-bit slice, no state.
module rev_operand_sel (
    input  logic       b,
    input  logic [1:0] mode,
    output logic       y,
    output logic       parity_o,
    output logic       g0,
    output logic       g1
);
    logic b_n;
    logic m1_copy;
    logic picked;
    logic m0_copy;
    logic parity;

    // Inverted copy of the operand bit.
    rev_not_gate u_inv (
        .a (b),
        .p (b_n)
    );

    // mode[1]=0 keeps b, mode[1]=1 takes ~b.
    rev_swap_gate u_swap_pol (
        .ctl   (mode[1]),
        .x     (b),
        .y     (b_n),
        .ctl_o (m1_copy),
        .q     (picked),
        .r     (g0)
    );

    // Parity of the mode bits, reusing the passed-through mode[1].
    rev_cnot_gate u_par (
        .ctl   (mode[0]),
        .tgt   (m1_copy),
        .ctl_o (m0_copy),
        .tgt_o (parity)
    );

    // Parity 0 selects the constant (mode[0]), parity 1 the picked value.
    rev_swap_gate u_swap_const (
        .ctl   (parity),
        .x     (m0_copy),
        .y     (picked),
        .ctl_o (parity_o),
        .q     (y),
        .r     (g1)
    );
endmodule

// File: rtl/rev_full_adder.sv
// Module: rev_full_adder - one-bit reversible full adder with a single
// constant-zero line. ADDER picks two cascaded Peres gates or one
// four-line gate; both expose a copy of a and a^b as garbage.
// Assumes: single-bit slice, no state.
module rev_full_adder
    import rev_arith_pkg::*;
#(
    parameter adder_kind_e ADDER = ADDER_PERES_PAIR
) (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co,
    output logic g_a,
    output logic g_ab
);
    localparam logic CONST_ZERO = 1'b0;

    generate
        if (ADDER == ADDER_PERES_PAIR) begin : g_peres
            logic ab_x;
            logic ab_and;

            // First gate: copy of a, parity a^b, AND a&b on the zero line.
            rev_peres_gate u_first (
                .a (a),
                .b (b),
                .c (CONST_ZERO),
                .p (g_a),
                .q (ab_x),
                .r (ab_and)
            );

            // Second gate: sum on q, majority carry on r.
            rev_peres_gate u_second (
                .a (ab_x),
                .b (ci),
                .c (ab_and),
                .p (g_ab),
                .q (s),
                .r (co)
            );
        end else begin : g_quad
            // Single four-line gate with its fourth input tied to zero.
            rev_quad_gate u_quad (
                .a (a),
                .b (b),
                .c (ci),
                .d (CONST_ZERO),
                .p (g_a),
                .q (g_ab),
                .r (s),
                .s (co)
            );
        end
    endgenerate
endmodule

// File: rtl/rev_slice.sv
// Module: rev_slice - one bit of the unit: operand selector followed by a
// reversible full adder; collects the slice's garbage lines.
// Assumes: carry arrives from the slice below, no state.
module rev_slice
    import rev_arith_pkg::*;
#(
    parameter adder_kind_e ADDER = ADDER_PERES_PAIR
) (
    input  logic           a,
    input  logic           b,
    input  logic [1:0]     mode,
    input  logic           ci,
    output logic           s,
    output logic           co,
    output slice_garbage_t garb
);
    logic opnd;
    logic par_l, sg0_l, sg1_l, ag0_l, ag1_l;

    // Second operand bit from b and the mode.
    rev_operand_sel u_sel (
        .b        (b),
        .mode     (mode),
        .y        (opnd),
        .parity_o (par_l),
        .g0       (sg0_l),
        .g1       (sg1_l)
    );

    // Add a, the chosen operand and the incoming carry.
    rev_full_adder #(.ADDER(ADDER)) u_fa (
        .a    (a),
        .b    (opnd),
        .ci   (ci),
        .s    (s),
        .co   (co),
        .g_a  (ag0_l),
        .g_ab (ag1_l)
    );

    // Bundle the leftover lines for observation.
    always_comb begin
        garb.sel_parity = par_l;
        garb.sel_g0     = sg0_l;
        garb.sel_g1     = sg1_l;
        garb.add_g0     = ag0_l;
        garb.add_g1     = ag1_l;
    end
endmodule

// File: rtl/rev_arith_unit.sv
// Module: rev_arith_unit - W-bit combinational arithmetic unit made of
// reversible slices; carries ripple from bit 0 upward.
// Assumes: inputs are steady 2-state values; no clock or reset is used.
module rev_arith_unit
    import rev_arith_pkg::*;
#(
    parameter int          W     = 8,
    parameter adder_kind_e ADDER = ADDER_PERES_PAIR
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   mode,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic         carry_out
);
    localparam int CHAIN_LEN = W + 1;

    logic [CHAIN_LEN-1:0]  carry;
    slice_garbage_t [W-1:0] garb;

    // Feed the external carry into the bottom of the chain.
    always_comb carry[0] = carry_in;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            rev_slice #(.ADDER(ADDER)) u_slice (
                .a    (op_a[i]),
                .b    (op_b[i]),
                .mode (mode),
                .ci   (carry[i]),
                .s    (result[i]),
                .co   (carry[i+1]),
                .garb (garb[i])
            );
        end
    endgenerate

    // Top of the chain leaves as the carry output.
    always_comb carry_out = carry[W];
endmodule

// File: rtl/rev_arith_checker.sv
// Module: rev_arith_checker - immediate assertions on the unit's ports and
// its per-slice garbage lines. The unit has no clock, so checks run
// whenever the observed values settle.
// Assumes: bound into rev_arith_unit; W matches the unit.
module rev_arith_checker
    import rev_arith_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0]           op_a,
    input logic [W-1:0]           op_b,
    input logic [1:0]             mode,
    input logic                   carry_in,
    input logic [W-1:0]           result,
    input logic                   carry_out,
    input slice_garbage_t [W-1:0] garb
);
    logic [W-1:0] opnd_exp;
    logic [W:0]   sum_exp;
    logic         known;

    // Expected operand and sum from the mode table.
    always_comb begin
        case (mode_e'(mode))
            MODE_ZERO:  opnd_exp = '0;
            MODE_B:     opnd_exp = op_b;
            MODE_NOT_B: opnd_exp = ~op_b;
            default:    opnd_exp = '1;
        endcase
        sum_exp = {1'b0, op_a} + {1'b0, opnd_exp} + {{W{1'b0}}, carry_in};
        known   = !$isunknown({op_a, op_b, mode, carry_in});
    end

    // Port-level result checks, one per mode.
    always_comb begin
        if (known) begin
            if (mode == 2'b00)
                assert_mode_zero_R1: assert ({carry_out, result} == sum_exp)
                    else $error("R1 mismatch");
            if (mode == 2'b01)
                assert_mode_add_R2: assert ({carry_out, result} == sum_exp)
                    else $error("R2 mismatch");
            if (mode == 2'b10)
                assert_mode_sub_R3: assert ({carry_out, result} == sum_exp)
                    else $error("R3 mismatch");
            if (mode == 2'b11 && carry_in)
                assert_mode_ones_hold_R4: assert (result == op_a && carry_out)
                    else $error("R4 mismatch");
            if (mode == 2'b11 && !carry_in)
                assert_mode_ones_dec_R4: assert ({carry_out, result} == sum_exp)
                    else $error("R4 mismatch");
            if (mode == 2'b00 && carry_in && op_a == '1)
                assert_full_ripple_R5: assert (result == '0 && carry_out)
                    else $error("R5 mismatch");
        end
    end

    // Garbage lines keep the information the datapath discards.
    always_comb begin
        if (known) begin
            for (int i = 0; i < W; i++) begin
                assert_garb_copy_a_R7: assert (garb[i].add_g0 == op_a[i])
                    else $error("R7 garbage a copy");
                assert_garb_mix_R7: assert (garb[i].add_g1 == (op_a[i] ^ opnd_exp[i]))
                    else $error("R7 garbage operand mix");
                assert_garb_parity_R7: assert (garb[i].sel_parity == (mode[0] ^ mode[1]))
                    else $error("R7 garbage parity");
                assert_garb_sel0_R7: assert (garb[i].sel_g0 == ~(op_b[i] ^ mode[1]))
                    else $error("R7 garbage first swap");
                assert_garb_sel1_R7: assert (garb[i].sel_g1 ==
                        ((mode[0] ^ mode[1]) ? mode[0] : (op_b[i] ^ mode[1])))
                    else $error("R7 garbage second swap");
            end
        end
    end
endmodule

bind rev_arith_unit rev_arith_checker #(.W(W)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .mode      (mode),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .garb      (garb)
);

// File: tb/sim_rev_arith_unit.sv
`timescale 1ns/1ps
// Bench: drives both adder variants with the same vectors, compares each
// against a behavioural sum computed from the requirement table.
module sim_rev_arith_unit;
    import rev_arith_pkg::*;

    localparam int W = 8;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] a, b;
    logic [1:0]   md;
    logic         ci;
    logic [W-1:0] f0, f1;
    logic         c0, c1;
    int           n_vec;
    int           n_bad;
    bit           done;

    rev_arith_unit #(.W(W), .ADDER(ADDER_PERES_PAIR)) u0 (
        .op_a (a), .op_b (b), .mode (md), .carry_in (ci),
        .result (f0), .carry_out (c0)
    );

    rev_arith_unit #(.W(W), .ADDER(ADDER_QUAD_GATE)) u1 (
        .op_a (a), .op_b (b), .mode (md), .carry_in (ci),
        .result (f1), .carry_out (c1)
    );

    // 200 MHz clock paces the vectors.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Reference: op_a plus the mode-selected operand plus carry.
    function automatic logic [W:0] ref_sum(logic [W-1:0] x, logic [W-1:0] y,
                                           logic [1:0] m, logic c);
        int unsigned opnd;
        case (m)
            2'b00:   opnd = 0;
            2'b01:   opnd = y;
            2'b10:   opnd = (~y) & ((1 << W) - 1);
            default: opnd = (1 << W) - 1;
        endcase
        return (W+1)'(x + opnd + c);
    endfunction

    function automatic string tag_of(logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Compare both instances with the expected sum.
    task automatic compare(string tag, logic [W:0] exp);
        n_vec++;
        if ({c0, f0} !== exp) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h mode=%b cin=%b got=%h exp=%h",
                     tag, a, b, md, ci, {c0, f0}, exp);
        end
        n_vec++;
        if ({c1, f1} !== exp) begin
            n_bad++;
            $display("FAIL R7 (%s) quad variant a=%h b=%h mode=%b cin=%b got=%h exp=%h",
                     tag, a, b, md, ci, {c1, f1}, exp);
        end
    endtask

    // Drive on a rising edge, sample on the following falling edge.
    task automatic apply(string tag, logic [W-1:0] x, logic [W-1:0] y,
                         logic [1:0] m, logic c);
        @(posedge clk);
        a = x; b = y; md = m; ci = c;
        @(negedge clk);
        compare(tag, ref_sum(x, y, m, c));
    endtask

    // Fixed expectations for the ripple and clockless cases.
    task automatic check_fixed(string tag, logic [W:0] exp);
        compare(tag, exp);
    endtask

    initial begin
        logic [W-1:0] pa [6];
        logic [W-1:0] pb [6];
        n_vec = 0; n_bad = 0; done = 0;
        rst_n = 1'b0;
        a = '0; b = '0; md = 2'b00; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle inputs: all zero gives zero result, no carry (R1).
        @(negedge clk);
        check_fixed("R1 idle", '0);

        pa[0] = 8'h00; pb[0] = 8'h00;
        pa[1] = 8'h00; pb[1] = 8'hFF;
        pa[2] = 8'hFF; pb[2] = 8'h00;
        pa[3] = 8'hFF; pb[3] = 8'hFF;
        pa[4] = 8'h01; pb[4] = 8'hFF;
        pa[5] = 8'h80; pb[5] = 8'h7F;

        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 6; k++)
                    apply(tag_of(2'(m)), pa[k], pb[k], 2'(m), 1'(c));
                for (int k = 0; k < 30; k++)
                    apply(tag_of(2'(m)), W'($urandom), W'($urandom), 2'(m), 1'(c));
            end
        end

        // R5: full-length ripple and the decrement of zero.
        apply("R5", 8'hFF, 8'h5A, 2'b00, 1'b1);
        check_fixed("R5 wrap", {1'b1, 8'h00});
        apply("R5", 8'h01, 8'hFF, 2'b01, 1'b0);
        check_fixed("R5 add wrap", {1'b1, 8'h00});
        apply("R4", 8'h00, 8'h33, 2'b11, 1'b0);
        check_fixed("R4 dec zero", {1'b0, 8'hFF});
        apply("R3", 8'h7F, 8'h80, 2'b10, 1'b1);
        check_fixed("R3 borrow", {1'b0, 8'hFF});

        // R6: change inputs mid-cycle, sample before any clock edge.
        @(negedge clk);
        a = 8'h3C; b = 8'h0F; md = 2'b01; ci = 1'b1;
        #1;
        check_fixed("R6", {1'b0, 8'h4C});
        md = 2'b10;
        #1;
        check_fixed("R6", {1'b1, 8'h2D});

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a miscompare.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule